// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns a 16-bit unsigned binary number into five packed BCD digits. It does not use a shift-and-add-3 network. It runs one bit-serial restoring divider five times over, dividing by ten on each pass. Each pass yields one remainder, which is the next decimal digit starting from the least significant. The quotient of that pass is the dividend for the next pass.

The block uses a level handshake. While `start` is low, everything is held cleared. Raising `start` samples `value_in` on the same clock edge and begins the conversion. `ready` rises once the fifth digit is stored. The digits then stay frozen until `start` falls. A synchronous active-high `rst` has the same clearing effect as a low `start`.

Top module: `bcd_conv_top`

## Requirements
- R1: A synchronous `rst` sampled high clears `ready` to 0 and `digits` to 0 at that edge, even in the middle of a conversion or after it has finished.
- R2: While `start` is sampled low, the next edge clears `ready` and `digits` to 0. A later rising `start` then runs a fresh conversion.
- R3: When `ready` is 1, nibble k of `digits` (bits 4k+3:4k, k=0..4) equals floor(V/10^k) mod 10, where V is the sampled input. The most significant decimal digit sits in bits 19:16 and the least significant in bits 3:0.
- R4: Every digit nibble that is written holds a value from 0 to 9. Each division pass leaves a remainder smaller than the divisor ten.
- R5: If `start` is first sampled high at edge 1, `ready` is 0 after edges 1 through 94 and becomes 1 after edge 95. That is five passes of 19 cycles each: one operand-load cycle, 16 quotient-bit cycles, one capture cycle and one restart cycle.
- R6: Once `ready` is 1 and `start` stays high, `ready` stays 1 and `digits` does not change, whatever `value_in` does.
- R7: `value_in` is sampled only on the edge where `start` is first seen high. Changes to it during the conversion have no effect on the result.
- R8: Input 65535 gives `digits` = 20'h65535, and input 0 gives 20'h00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Level request; low clears, high runs and then holds |
| value_in | input | 16 | Unsigned binary value to convert |
| ready | output | 1 | High when all five digits are valid |
| digits | output | 20 | Packed BCD digits, most significant digit in bits 19:16 |

## Verification
Two events can fall on the same edge: the capture of the last digit and a change of the handshake inputs. The sharpest cases are a drop of `start` or an `rst` pulse at the moment the converter would raise `ready` or store a digit.

The bench provokes this in three ways. It pulses `rst` while a conversion is running and again after it has completed. It changes `value_in` a few cycles into a pass. It changes `value_in` again once `ready` is high.

Each time, it judges the result at the ports. A clear must win, leaving `ready` and `digits` at zero on the next edge. A late input change must leave the digits equal to the decimal expansion of the originally sampled value, computed by a bench function.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    localparam int CONV_IN_W   = 16;
    localparam int CONV_DIGITS = 5;
    localparam int NIB_W       = 4;
    localparam int RADIX       = 10;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_GAP,
        SEQ_DONE
    } seq_state_e;

    // Cycles per pass: operand load, one per quotient bit, capture, restart.
    function automatic int pass_cycles(input int in_w);
        return in_w + 3;
    endfunction

endpackage

// File: rtl/bcd_divider.sv
module bcd_divider
    import bcd_conv_pkg::*;
#(
    parameter int W = CONV_IN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    localparam int STEP_W = $clog2(W + 1);

    logic [STEP_W-1:0] step;
    logic [W-1:0]      dvd_sh;
    logic [W-1:0]      dvs;
    logic [W:0]        trial;
    logic              take;

    // Pull the next dividend bit into the partial remainder and test it.
    assign trial = {rem, dvd_sh[W-1]};
    assign take  = (trial >= {1'b0, dvs});

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            step   <= '0;
            done   <= 1'b0;
            quo    <= '0;
            rem    <= '0;
            dvd_sh <= '0;
            dvs    <= '0;
        end else if (step == '0) begin
            dvd_sh <= dividend;
            dvs    <= divisor;
            step   <= STEP_W'(1);
        end else if (!done) begin
            rem    <= take ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
            quo    <= {quo[W-2:0], take};
            dvd_sh <= dvd_sh << 1;
            if (step == STEP_W'(W))
                done <= 1'b1;
            else
                step <= step + STEP_W'(1);
        end
    end

    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (step > STEP_W'(1) || done) && dvs != '0 |-> rem < dvs)
        else $error("remainder not below divisor");

    p_step_limit_r5: assert property (@(posedge clk) disable iff (rst)
        step <= STEP_W'(W))
        else $error("step counter out of range");

endmodule

// File: rtl/bcd_digit_store.sv
module bcd_digit_store
    import bcd_conv_pkg::*;
#(
    parameter int DIGITS = CONV_DIGITS,
    parameter int DW     = NIB_W
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [$clog2(DIGITS)-1:0] wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic [DIGITS*DW-1:0]      packed_out
);

    localparam int IDX_W = $clog2(DIGITS);

    // Slot 0 holds the least significant digit.
    for (genvar g = 0; g < DIGITS; g++) begin : g_slot
        logic [DW-1:0] nib;
        always_ff @(posedge clk) begin
            if (clr)
                nib <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                nib <= wr_data;
        end
        assign packed_out[g*DW +: DW] = nib;
    end

endmodule

// File: rtl/bcd_sequencer.sv
module bcd_sequencer
    import bcd_conv_pkg::*;
#(
    parameter int W      = CONV_IN_W,
    parameter int DIGITS = CONV_DIGITS,
    parameter int DW     = NIB_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [W-1:0]              value_in,
    input  logic                      div_done,
    input  logic [W-1:0]              div_quo,
    input  logic [W-1:0]              div_rem,
    output logic                      div_go,
    output logic [W-1:0]              work,
    output logic                      clr,
    output logic                      wr_en,
    output logic [$clog2(DIGITS)-1:0] wr_idx,
    output logic [DW-1:0]             wr_data,
    output logic                      ready
);

    localparam int IDX_W = $clog2(DIGITS);

    seq_state_e       state;
    logic [IDX_W-1:0] pass;

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            state <= SEQ_IDLE;
            pass  <= '0;
            work  <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    work  <= value_in;
                    pass  <= '0;
                    state <= SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (div_done) begin
                        work <= div_quo;
                        if (pass == IDX_W'(DIGITS - 1)) begin
                            state <= SEQ_DONE;
                        end else begin
                            pass  <= pass + IDX_W'(1);
                            state <= SEQ_GAP;
                        end
                    end
                end
                SEQ_GAP:  state <= SEQ_RUN;
                SEQ_DONE: state <= SEQ_DONE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign div_go  = (state == SEQ_RUN);
    assign clr     = rst || !start;
    assign wr_en   = (state == SEQ_RUN) && div_done && start && !rst;
    assign wr_idx  = pass;
    assign wr_data = div_rem[DW-1:0];
    assign ready   = (state == SEQ_DONE);

    p_digit_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (div_rem < W'(RADIX)))
        else $error("digit out of decimal range");

    p_drop_clears_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> !ready)
        else $error("ready survived a low start");

    p_ready_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(start))
        else $error("ready rose without start");

endmodule

// File: rtl/bcd_conv_top.sv
module bcd_conv_top
    import bcd_conv_pkg::*;
#(
    parameter int W      = CONV_IN_W,
    parameter int DIGITS = CONV_DIGITS,
    parameter int DW     = NIB_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [W-1:0]         value_in,
    output logic                 ready,
    output logic [DIGITS*DW-1:0] digits
);

    localparam int IDX_W = $clog2(DIGITS);

    logic             div_go;
    logic             div_done;
    logic [W-1:0]     div_quo;
    logic [W-1:0]     div_rem;
    logic [W-1:0]     work;
    logic             clr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;

    bcd_sequencer #(.W(W), .DIGITS(DIGITS), .DW(DW)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .value_in (value_in),
        .div_done (div_done),
        .div_quo  (div_quo),
        .div_rem  (div_rem),
        .div_go   (div_go),
        .work     (work),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .ready    (ready)
    );

    bcd_divider #(.W(W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (work),
        .divisor  (W'(RADIX)),
        .done     (div_done),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    bcd_digit_store #(.DIGITS(DIGITS), .DW(DW)) i_store (
        .clk        (clk),
        .clr        (clr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .packed_out (digits)
    );

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> (ready && $stable(digits)))
        else $error("result not held");

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!ready && digits == '0))
        else $error("reset did not clear");

endmodule

// File: tb/test_bcd_conv_top.sv
module test_bcd_conv_top;

    localparam int W       = 16;
    localparam int DIGITS  = 5;
    localparam int LATENCY = DIGITS * (W + 3);

    logic                clk = 1'b0;
    logic                rst;
    logic                start;
    logic [W-1:0]        value_in;
    logic                ready;
    logic [DIGITS*4-1:0] digits;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bcd_conv_top i_bcd_conv_top (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .value_in (value_in),
        .ready    (ready),
        .digits   (digits)
    );

    function automatic logic [DIGITS*4-1:0] exp_bcd(input int unsigned v);
        logic [DIGITS*4-1:0] r = '0;
        int unsigned x = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[k*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One full conversion; optionally disturbs value_in mid-pass.
    task automatic convert(input logic [W-1:0] v, input bit disturb,
                           input logic [W-1:0] other);
        bit early = 1'b0;
        logic [DIGITS*4-1:0] want = exp_bcd(v);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!ready && digits == '0, "R2 clear on low start",
              {ready, digits}, 0);
        value_in = v;
        start = 1'b1;
        for (int n = 1; n <= LATENCY; n++) begin
            @(posedge clk); @(negedge clk);
            if (disturb && n == 3) value_in = other;
            if (n < LATENCY && ready) early = 1'b1;
        end
        check(!early && ready, "R5 ready timing", {early, ready}, 1);
        check(digits == want, disturb ? "R7 late input ignored" : "R3 digits",
              digits, want);
        for (int k = 0; k < DIGITS; k++)
            check(digits[k*4 +: 4] <= 4'd9, "R4 nibble range",
                  digits[k*4 +: 4], 9);
        value_in = ~v;
        repeat (3) @(negedge clk);
        check(ready && digits == want, "R6 hold while start high",
              {ready, digits}, {1'b1, want});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        value_in = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ready && digits == '0, "R1 reset state", {ready, digits}, 0);
        rst = 1'b0;

        convert(16'd65535, 1'b0, '0);
        check(digits == 20'h65535, "R8 max input", digits, 20'h65535);
        convert(16'd0, 1'b0, '0);
        check(digits == 20'h00000, "R8 zero input", digits, 0);
        convert(16'd9, 1'b0, '0);
        convert(16'd10, 1'b0, '0);
        convert(16'd9999, 1'b0, '0);
        convert(16'd10000, 1'b0, '0);
        convert(16'd12345, 1'b1, 16'd54321);

        // Reset during a conversion.
        @(negedge clk); start = 1'b0;
        @(negedge clk); value_in = 16'd4321; start = 1'b1;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!ready && digits == '0, "R1 reset mid conversion",
              {ready, digits}, 0);
        rst = 1'b0;

        // Reset after a finished conversion.
        convert(16'd777, 1'b0, '0);
        rst = 1'b1;
        @(negedge clk);
        check(!ready && digits == '0, "R1 reset after done",
              {ready, digits}, 0);
        rst = 1'b0;

        for (int i = 0; i < 150; i++) begin
            logic [W-1:0] rv = W'($urandom);
            convert(rv, (i % 4) == 0, W'($urandom));
        end

        finish_run();
    end

endmodule